// File: doc/BRIEF.md
# Per-Row Digital Flux-Locked Loop

This block closes one digital feedback loop for each row of a time-multiplexed sensor readout. Rows are visited one after another. While a row is selected, the block adds up the ADC samples that the sample strobe marks. The row's visit ends on the end-of-row strobe. At that point the summed error updates the row's stored feedback code through a gain and an arithmetic right shift, with saturation to the DAC code range. The updated code is written back to a per-row store, and it drives the feedback DAC word the next time that row is selected.

Several columns run side by side. Each column has its own accumulator, its own update datapath and its own per-row store. All columns share the row index and the strobes. Each column also has one arithmetic datapath that serves every row in turn, because the row state is read and written once per visit. At every end of row, a record goes out on a valid/ready stream for acquisition. The record holds the row index, each column's summed error and each column's new feedback code.

Top module: `tdm_row_fll`

## Requirements
- R1: After reset, every row of every column holds mid-scale feedback 2^(DAC_W-1), `dac_o` shows mid-scale and `st_valid_o` is low.
- R2: A row's error is the signed sum of the two's-complement ADC samples strobed by `sample_i` since the previous end of row. A sample strobed in the same cycle as `eor_i` is dropped.
- R3: Only the first MAX_SAMPLES (default 16) strobed samples of a visit are summed. Later samples in the same visit are ignored.
- R4: At end of row with the row's lock bit set, the new feedback is old + ((gain × error) >>> shift). `gain_i` is unsigned, and the shift is arithmetic, so it rounds toward minus infinity.
- R5: The new feedback saturates to the range 0 to 2^DAC_W-1.
- R6: When `lock_en_i[row]` is 0, the row's feedback stays the same at end of row, and a record is still emitted.
- R7: `dac_o` is a register. It shows the stored feedback of the row that `row_i` selected at the previous clock edge, so a written-back value appears when its row is next selected.
- R8: An update changes only the stored state of the row given by `row_i` in the `eor_i` cycle.
- R9: The columns are independent. Column c uses bits [c*W +: W] of each packed port, where W is that port's per-column width.
- R10: In the cycle after an end of row, `st_valid_o` is high with the row index, errors and new feedback codes. The record is held stable while `st_ready_i` is low and is dropped after a cycle with `st_ready_i` high.
- R11: A new end of row replaces a record that has not yet been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| row_i | input | ROW_W | Index of the currently selected row |
| sample_i | input | 1 | ADC sample strobe |
| eor_i | input | 1 | End-of-row strobe |
| adc_i | input | NUM_COLS*ADC_W | Signed ADC samples, one per column |
| lock_en_i | input | NUM_ROWS | Per-row loop enable |
| gain_i | input | GAIN_W | Unsigned loop gain |
| shift_i | input | SHIFT_W | Right-shift amount applied to gain × error |
| dac_o | output | NUM_COLS*DAC_W | Feedback DAC codes, one per column |
| st_valid_o | output | 1 | Stream record valid |
| st_ready_i | input | 1 | Stream record accepted |
| st_row_o | output | ROW_W | Row index of the record |
| st_err_o | output | NUM_COLS*ACC_W | Summed errors, one per column |
| st_fb_o | output | NUM_COLS*DAC_W | New feedback codes, one per column |

## Verification
The bench targets the following corner cases:
- **Negative product that does not divide evenly by the shift.** A design that truncates toward zero would land one code too high.
- **More than sixteen samples in one visit.** A design without a cap would sum every sample.
- **A sample that coincides with the end-of-row strobe.** A design that counted it would report the wrong error.
- **Saturation at both ends of the code range.** A design with an unsigned or narrow sum would wrap around instead of clamping.
- **Rows with the lock bit cleared.** A design that ignored the bit would drift.
- **Rows and columns fed different data.** A design that shared state would mix them up.
- **A stalled stream.** A design could lose the held record, or keep a stale one when a newer end of row arrives.

// File: rtl/tdm_fll_pkg.sv
package tdm_fll_pkg;
  function automatic int unsigned cnt_width(int unsigned max_samples);
    return $clog2(max_samples + 1);
  endfunction

  function automatic int unsigned acc_width(int unsigned adc_w, int unsigned max_samples);
    return adc_w + $clog2(max_samples + 1);
  endfunction
endpackage

// File: rtl/fll_accum.sv
module fll_accum #(
  parameter int unsigned ADC_W       = 12,
  parameter int unsigned MAX_SAMPLES = 16,
  parameter int unsigned ACC_W       = tdm_fll_pkg::acc_width(ADC_W, MAX_SAMPLES),
  parameter int unsigned CNT_W       = tdm_fll_pkg::cnt_width(MAX_SAMPLES)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sample_i,
  input  logic                    eor_i,
  input  logic [ADC_W-1:0]        adc_i,
  output logic signed [ACC_W-1:0] err_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_SAMPLES);

  logic [CNT_W-1:0]        cnt_q;
  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] adc_ext;

  assign adc_ext = $signed({{(ACC_W-ADC_W){adc_i[ADC_W-1]}}, adc_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (eor_i) begin
      cnt_q <= '0;  // coincident sample dropped
      acc_q <= '0;
    end else if (sample_i && cnt_q < CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
      acc_q <= acc_q + adc_ext;
    end
  end

  assign err_o = acc_q;

  assert_sample_cap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !eor_i) |=> $stable(acc_q));

  assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX);

  assert_eor_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eor_i |=> (acc_q == '0));
endmodule

// File: rtl/fll_update.sv
module fll_update #(
  parameter int unsigned ACC_W   = 17,
  parameter int unsigned DAC_W   = 14,
  parameter int unsigned GAIN_W  = 8,
  parameter int unsigned SHIFT_W = 4
) (
  input  logic [DAC_W-1:0]        fb_i,
  input  logic signed [ACC_W-1:0] err_i,
  input  logic [GAIN_W-1:0]       gain_i,
  input  logic [SHIFT_W-1:0]      shift_i,
  input  logic                    lock_i,
  output logic [DAC_W-1:0]        fb_o
);
  localparam int unsigned PROD_W = ACC_W + GAIN_W + 1;
  localparam int unsigned SUM_W  = PROD_W + 1;
  localparam logic signed [SUM_W-1:0] CODE_MAX = SUM_W'((64'd1 << DAC_W) - 64'd1);

  logic signed [PROD_W-1:0] err_ext, gain_ext, prod, step;
  logic signed [SUM_W-1:0]  sum;

  assign err_ext  = $signed({{(PROD_W-ACC_W){err_i[ACC_W-1]}}, err_i});
  assign gain_ext = $signed({{(PROD_W-GAIN_W){1'b0}}, gain_i});
  assign prod     = err_ext * gain_ext;
  assign step     = prod >>> shift_i;
  assign sum      = $signed({{(SUM_W-DAC_W){1'b0}}, fb_i}) + $signed({step[PROD_W-1], step});

  always_comb begin
    if (!lock_i)               fb_o = fb_i;
    else if (sum[SUM_W-1])     fb_o = '0;
    else if (sum > CODE_MAX)   fb_o = '1;
    else                       fb_o = sum[DAC_W-1:0];
  end
endmodule

// File: rtl/fll_lane.sv
module fll_lane #(
  parameter int unsigned NUM_ROWS    = 4,
  parameter int unsigned ADC_W       = 12,
  parameter int unsigned DAC_W       = 14,
  parameter int unsigned GAIN_W      = 8,
  parameter int unsigned SHIFT_W     = 4,
  parameter int unsigned MAX_SAMPLES = 16,
  parameter int unsigned ROW_W       = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1,
  parameter int unsigned ACC_W       = tdm_fll_pkg::acc_width(ADC_W, MAX_SAMPLES)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ROW_W-1:0]        row_i,
  input  logic                    sample_i,
  input  logic                    eor_i,
  input  logic [ADC_W-1:0]        adc_i,
  input  logic [NUM_ROWS-1:0]     lock_en_i,
  input  logic [GAIN_W-1:0]       gain_i,
  input  logic [SHIFT_W-1:0]      shift_i,
  output logic [DAC_W-1:0]        dac_o,
  output logic signed [ACC_W-1:0] err_o,
  output logic [DAC_W-1:0]        fb_nxt_o
);
  localparam logic [DAC_W-1:0] MID = DAC_W'(64'd1 << (DAC_W - 1));

  logic [DAC_W-1:0] fb_mem [NUM_ROWS];
  logic [DAC_W-1:0] dac_q;
  logic             lock_sel;

  assign lock_sel = lock_en_i[row_i];

  fll_accum #(
    .ADC_W(ADC_W), .MAX_SAMPLES(MAX_SAMPLES), .ACC_W(ACC_W)
  ) u_accum (
    .clk_i(clk_i), .rst_ni(rst_ni), .sample_i(sample_i), .eor_i(eor_i),
    .adc_i(adc_i), .err_o(err_o)
  );

  fll_update #(
    .ACC_W(ACC_W), .DAC_W(DAC_W), .GAIN_W(GAIN_W), .SHIFT_W(SHIFT_W)
  ) u_update (
    .fb_i(fb_mem[row_i]), .err_i(err_o), .gain_i(gain_i), .shift_i(shift_i),
    .lock_i(lock_sel), .fb_o(fb_nxt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NUM_ROWS; r++) fb_mem[r] <= MID;
      dac_q <= MID;
    end else begin
      if (eor_i) fb_mem[row_i] <= fb_nxt_o;
      dac_q <= fb_mem[row_i];
    end
  end

  assign dac_o = dac_q;

  assert_lock_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eor_i && !lock_sel) |=> fb_mem[$past(row_i)] == $past(fb_mem[row_i]));

  assert_step_dir_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eor_i && lock_sel && err_o > 0) |=> fb_mem[$past(row_i)] >= $past(fb_mem[row_i]));
endmodule

// File: rtl/tdm_row_fll.sv
module tdm_row_fll #(
  parameter int unsigned NUM_COLS    = 2,
  parameter int unsigned NUM_ROWS    = 4,
  parameter int unsigned ADC_W       = 12,
  parameter int unsigned DAC_W       = 14,
  parameter int unsigned GAIN_W      = 8,
  parameter int unsigned SHIFT_W     = 4,
  parameter int unsigned MAX_SAMPLES = 16,
  localparam int unsigned ROW_W      = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1,
  localparam int unsigned ACC_W      = tdm_fll_pkg::acc_width(ADC_W, MAX_SAMPLES)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [ROW_W-1:0]             row_i,
  input  logic                         sample_i,
  input  logic                         eor_i,
  input  logic [NUM_COLS*ADC_W-1:0]    adc_i,
  input  logic [NUM_ROWS-1:0]          lock_en_i,
  input  logic [GAIN_W-1:0]            gain_i,
  input  logic [SHIFT_W-1:0]           shift_i,
  output logic [NUM_COLS*DAC_W-1:0]    dac_o,
  output logic                         st_valid_o,
  input  logic                         st_ready_i,
  output logic [ROW_W-1:0]             st_row_o,
  output logic [NUM_COLS*ACC_W-1:0]    st_err_o,
  output logic [NUM_COLS*DAC_W-1:0]    st_fb_o
);
  logic [NUM_COLS*ACC_W-1:0] err_all;
  logic [NUM_COLS*DAC_W-1:0] fb_all;

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    logic signed [ACC_W-1:0] err_c;
    fll_lane #(
      .NUM_ROWS(NUM_ROWS), .ADC_W(ADC_W), .DAC_W(DAC_W), .GAIN_W(GAIN_W),
      .SHIFT_W(SHIFT_W), .MAX_SAMPLES(MAX_SAMPLES)
    ) u_lane (
      .clk_i(clk_i), .rst_ni(rst_ni), .row_i(row_i), .sample_i(sample_i),
      .eor_i(eor_i), .adc_i(adc_i[c*ADC_W +: ADC_W]), .lock_en_i(lock_en_i),
      .gain_i(gain_i), .shift_i(shift_i), .dac_o(dac_o[c*DAC_W +: DAC_W]),
      .err_o(err_c), .fb_nxt_o(fb_all[c*DAC_W +: DAC_W])
    );
    assign err_all[c*ACC_W +: ACC_W] = err_c;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_valid_o <= 1'b0;
      st_row_o   <= '0;
      st_err_o   <= '0;
      st_fb_o    <= '0;
    end else if (eor_i) begin
      st_valid_o <= 1'b1;  // newest record wins
      st_row_o   <= row_i;
      st_err_o   <= err_all;
      st_fb_o    <= fb_all;
    end else if (st_ready_i) begin
      st_valid_o <= 1'b0;
    end
  end

  assert_stream_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_valid_o && !st_ready_i && !eor_i) |=>
      (st_valid_o && $stable(st_row_o) && $stable(st_err_o) && $stable(st_fb_o)));

  assert_stream_drop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_valid_o && st_ready_i && !eor_i) |=> !st_valid_o);

  assert_record_row_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eor_i |=> (st_valid_o && st_row_o == $past(row_i)));
endmodule

// File: tb/tdm_row_fll_tb.sv
module tdm_row_fll_tb;
  localparam int NC = 2, NR = 4, AW = 12, DW = 14, GW = 8, SW = 4, MS = 16;
  localparam int CW = AW + $clog2(MS + 1);
  localparam int MID = 1 << (DW - 1);
  localparam int CMAX = (1 << DW) - 1;

  logic clk = 0, rst_n = 0;
  logic [1:0] row = 0;
  logic sample = 0, eor = 0, rdy = 1;
  logic [NC*AW-1:0] adc = '0;
  logic [NR-1:0] lock = '1;
  logic [GW-1:0] gain = 0;
  logic [SW-1:0] shift = 0;
  logic [NC*DW-1:0] dac, st_fb;
  logic [NC*CW-1:0] st_err;
  logic st_valid;
  logic [1:0] st_row;

  int errors = 0, checks = 0;
  int exp_fb [NC][NR];
  int last_err [NC];

  always #10 clk = ~clk;

  tdm_row_fll #(.NUM_COLS(NC), .NUM_ROWS(NR), .ADC_W(AW), .DAC_W(DW), .GAIN_W(GW),
    .SHIFT_W(SW), .MAX_SAMPLES(MS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .row_i(row), .sample_i(sample), .eor_i(eor),
    .adc_i(adc), .lock_en_i(lock), .gain_i(gain), .shift_i(shift), .dac_o(dac),
    .st_valid_o(st_valid), .st_ready_i(rdy), .st_row_o(st_row), .st_err_o(st_err),
    .st_fb_o(st_fb));

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int col_dac(int c); return int'(dac[c*DW +: DW]); endfunction
  function automatic int col_fb(int c);  return int'(st_fb[c*DW +: DW]); endfunction
  function automatic int col_err(int c); return int'($signed(st_err[c*CW +: CW])); endfunction

  // n samples: col0 = b0 + k*st, col1 = b1 - k*st; junk sample at eor when extra
  task automatic visit(input int r, input int n, input int b0, input int b1, input int st,
                       input bit extra, input bit chk_stream, input string req);
    int sum [NC];
    longint s;
    sum[0] = 0; sum[1] = 0;
    @(negedge clk); row = 2'(r); sample = 0; eor = 0;
    @(negedge clk);
    for (int c = 0; c < NC; c++) check({req, " R7 dac"}, col_dac(c), exp_fb[c][r]);
    for (int k = 0; k < n; k++) begin
      sample = 1;
      adc[0 +: AW]  = AW'(b0 + k*st);
      adc[AW +: AW] = AW'(b1 - k*st);
      if (k < MS) begin sum[0] += b0 + k*st; sum[1] += b1 - k*st; end
      @(negedge clk);
    end
    sample = extra; adc = {AW'(1500), AW'(-1500)}; eor = 1;
    @(negedge clk); eor = 0; sample = 0;
    for (int c = 0; c < NC; c++) begin
      if (lock[r]) begin
        s = longint'(exp_fb[c][r]) + ((longint'(gain) * sum[c]) >>> shift);
        if (s < 0) s = 0;
        if (s > CMAX) s = CMAX;
        exp_fb[c][r] = int'(s);
      end
      last_err[c] = sum[c];
    end
    if (chk_stream) begin
      check({req, " R10 valid"}, st_valid, 1);
      check({req, " R10 row"}, st_row, r);
      for (int c = 0; c < NC; c++) begin
        check({req, " err"}, col_err(c), sum[c]);
        check({req, " fb"}, col_fb(c), exp_fb[c][r]);
      end
    end
  endtask

  task automatic t_reset;
    check("R1 valid low", st_valid, 0);
    for (int c = 0; c < NC; c++) check("R1 dac mid", col_dac(c), MID);
    gain = 5; shift = 0;
    for (int r = 0; r < NR; r++) visit(r, 0, 0, 0, 0, 0, 1, "R1");
  endtask

  task automatic t_basic;
    gain = 4; shift = 3;
    visit(1, 5, 100, -50, 10, 0, 1, "R4 basic");
    visit(1, 3, 7, 9, 1, 0, 1, "R4 second visit");
  endtask

  task automatic t_floor;
    gain = 3; shift = 2;  // err -5 -> -15 >>> 2 = -4
    visit(2, 5, -1, 1, 0, 0, 1, "R4 floor");
  endtask

  task automatic t_eor_sample;
    gain = 1; shift = 0;
    visit(0, 2, 10, 20, 0, 1, 1, "R2 eor sample");
    check("R2 err col0", last_err[0], 20);
  endtask

  task automatic t_cap;
    gain = 1; shift = 4;
    visit(3, 20, 50, -30, 1, 0, 1, "R3 cap");
  endtask

  task automatic t_sat;
    gain = 255; shift = 0;
    visit(0, 16, 2000, -2000, 0, 0, 1, "R5 sat");
    check("R5 high", exp_fb[0][0], CMAX);
    check("R5 low", exp_fb[1][0], 0);
    visit(0, 16, -2000, 2000, 0, 0, 1, "R5 sat swap");
  endtask

  task automatic t_lock;
    int held;
    gain = 8; shift = 0;
    lock[3] = 0;
    held = exp_fb[0][3];
    visit(3, 4, 300, 300, 0, 0, 1, "R6 lock off");
    check("R6 held", col_fb(0), held);
    visit(3, 1, 0, 0, 0, 0, 1, "R6 revisit");
    lock[3] = 1;
  endtask

  task automatic t_rows;
    gain = 2; shift = 1;
    visit(2, 4, 40, -40, 5, 0, 1, "R8 row2");
    for (int r = 0; r < NR; r++) visit(r, 0, 0, 0, 0, 0, 1, "R8 sweep");
    visit(1, 6, -100, 200, -7, 0, 1, "R9 cols");
  endtask

  task automatic t_stream;
    gain = 1; shift = 0;
    rdy = 0;
    visit(1, 2, 11, 22, 0, 0, 1, "R10 stall");
    repeat (3) @(negedge clk);
    check("R10 held valid", st_valid, 1);
    check("R10 held row", st_row, 1);
    check("R10 held err", col_err(0), 22);
    visit(2, 1, 33, 44, 0, 0, 1, "R11 replace");
    check("R11 row", st_row, 2);
    rdy = 1;
    @(negedge clk);
    check("R10 drop", st_valid, 0);
  endtask

  initial begin
    for (int c = 0; c < NC; c++) for (int r = 0; r < NR; r++) exp_fb[c][r] = MID;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_floor();
    t_eor_sample();
    t_cap();
    t_sat();
    t_lock();
    t_rows();
    t_stream();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule